// File: doc/BRIEF.md
# SPI Master First-Word Start Delay

This block sits between the transmit-side control of an SPI master channel and its shift engine. It holds back the start request for the first word after a channel is switched on. Once the channel is enabled and the first transmit write arrives, the block can wait a programmed number of SPI clock periods before it lets shifting begin. Software or DMA can use that time to top up the transmit FIFO, so the first burst is not starved.

The hold-off is counted in SPI clock periods. Each period is marked by a one-cycle clock-enable tick from the clock divider. The hold-off happens once per enable, and only when the channel is a master running in single-channel mode. In every other configuration the start request follows the first write at once. The start request is a level. It rises when shifting is allowed and stays high until the channel is disabled, so later words never see a hold-off. Disabling the channel re-arms the hold-off for the next enable.

Top module: `spi_first_word_delay`

## Requirements
- R1: While reset is applied and on the first sample after it is released, `start_req` is 0.
- R2: `start_req` stays 0 until a `tx_write` is sampled while `chan_en` is 1. A `tx_write` sampled while `chan_en` is 0 has no effect.
- R3: When no hold-off applies, `start_req` is 1 from the clock edge that samples the first `tx_write`. The code values 0, 5, 6 and 7 on `dly_sel` select no hold-off.
- R4: `dly_sel` codes 1, 2, 3 and 4 select hold-offs of 4, 8, 16 and 32 SPI periods. `start_req` rises at the edge that samples the Nth `sclk_tick` after the cycle of the first write. A tick in the write cycle itself is not counted.
- R5: The hold-off counts `sclk_tick` pulses, not system clock cycles. Cycles without a tick do not advance it.
- R6: A hold-off applies only when `master_mode` and `single_mode` are both 1 at the first write. Any other combination behaves as in R3.
- R7: Once `start_req` is 1, it stays 1 while `chan_en` stays 1. Further writes and ticks cause no new hold-off.
- R8: `chan_en` sampled at 0 clears `start_req` and any hold-off in progress at the next edge. A later enable and write run the full hold-off again.
- R9: `dly_sel`, `master_mode` and `single_mode` are captured at the first write. Changing them while the hold-off runs does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; low cancels and re-arms |
| tx_write | input | 1 | One-cycle strobe for a write to the transmit data register |
| master_mode | input | 1 | Channel operates as SPI master |
| single_mode | input | 1 | Single-channel mode selected |
| dly_sel | input | 3 | Hold-off select code |
| sclk_tick | input | 1 | One-cycle tick per SPI clock period |
| start_req | output | 1 | Level start request to the shift engine |

## Verification
The main sweep covers every `dly_sel` code under all four master/single flag combinations. It runs with ticks on every cycle and again with ticks every third cycle. This separates tick counting from clock counting, and the correct lengths from off-by-one errors. It also shows that the unused codes and the non-master or non-single modes fall back to no hold-off. Separate sequences do the following:
- drop the enable part-way through a hold-off, to show the cancel and the full re-arm;
- write while the channel is disabled, to show the write is ignored;
- change the select code during a hold-off, to show the length was fixed at the first write.

// File: rtl/spi_fwd_pkg.sv
package spi_fwd_pkg;

   typedef enum logic [1:0] {
      FWD_IDLE = 2'd0,
      FWD_WAIT = 2'd1,
      FWD_RUN  = 2'd2
   } fwd_state_t;

endpackage

// File: rtl/fwd_decode.sv
module fwd_decode #(
   parameter int SEL_W      = 3,
   parameter int MIN_LOG    = 2,
   parameter int MAX_LOG    = 5,
   parameter int TGT_W      = MAX_LOG + 1,
   parameter bit SHIFT_IMPL = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             master_mode,
   input  logic             single_mode,
   output logic [TGT_W-1:0] tgt
);
   localparam int NUM_STEPS = MAX_LOG - MIN_LOG + 1;

   initial begin
      assert (MIN_LOG >= 0 && MAX_LOG >= MIN_LOG)
         else $error("fwd_decode: bad log range");
      assert ((1 << SEL_W) > NUM_STEPS)
         else $error("fwd_decode: SEL_W too narrow");
      assert (TGT_W > MAX_LOG)
         else $error("fwd_decode: TGT_W too narrow");
   end

   logic             code_ok;
   logic [TGT_W-1:0] raw;

   assign code_ok = (sel != '0) && (int'(sel) <= NUM_STEPS);

   generate
      if (SHIFT_IMPL) begin : g_shift
         always_comb begin
            raw = '0;
            if (code_ok) raw = TGT_W'(1) << (int'(sel) + MIN_LOG - 1);
         end
      end else begin : g_table
         always_comb begin
            raw = '0;
            for (int k = 1; k <= NUM_STEPS; k++) begin
               if (int'(sel) == k) raw = TGT_W'(1) << (k + MIN_LOG - 1);
            end
         end
      end
   endgenerate

   assign tgt = (master_mode && single_mode) ? raw : '0;

endmodule

// File: rtl/fwd_counter.sv
module fwd_counter #(
   parameter int TGT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [TGT_W-1:0] load_tgt,
   input  logic             count_en,
   input  logic             tick,
   output logic             done
);
   logic [TGT_W-1:0] tgt_q;
   logic [TGT_W-1:0] cnt_q;
   logic             last;

   initial begin
      assert (TGT_W >= 2) else $error("fwd_counter: TGT_W too small");
   end

   assign last = (cnt_q == tgt_q - TGT_W'(1));
   assign done = count_en && tick && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         tgt_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         tgt_q <= load_tgt;
         cnt_q <= '0;
      end else if (count_en && tick) begin
         cnt_q <= last ? '0 : cnt_q + TGT_W'(1);
      end
   end

   // R4: the running count never reaches the captured target
   assert_cnt_below_tgt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && tgt_q != '0) |-> (cnt_q < tgt_q));

   // R9: target stays fixed while counting
   assert_tgt_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && !clear && !load) |=> (tgt_q == $past(tgt_q)));

   // R5: count does not move without a tick
   assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clear && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/fwd_fsm.sv
module fwd_fsm
   import spi_fwd_pkg::*;
#(
   parameter int TGT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             tx_write,
   input  logic [TGT_W-1:0] tgt,
   input  logic             done,
   output logic             clear,
   output logic             load,
   output logic             count_en,
   output logic             start_req
);
   fwd_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FWD_IDLE: if (chan_en && tx_write) state_d = (tgt == '0) ? FWD_RUN : FWD_WAIT;
         FWD_WAIT: if (done) state_d = FWD_RUN;
         FWD_RUN:  state_d = FWD_RUN;
         default:  state_d = FWD_IDLE;
      endcase
      if (!chan_en) state_d = FWD_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FWD_IDLE;
      else        state_q <= state_d;
   end

   assign clear     = !chan_en;
   assign load      = (state_q == FWD_IDLE) && chan_en && tx_write;
   assign count_en  = (state_q == FWD_WAIT) && chan_en;
   assign start_req = (state_q == FWD_RUN);

   // R8: a disabled channel leaves no start request
   assert_dis_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !start_req);

   // R7: the request only falls after a disable
   assert_hold_while_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_req) |-> !$past(chan_en));

   // R2: the request only rises from a sampled enable
   assert_rise_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_req) |-> $past(chan_en));

   // R4: leaving the wait happens only on a completed count
   assert_wait_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FWD_WAIT && chan_en && !done) |=> (state_q == FWD_WAIT));

endmodule

// File: rtl/spi_first_word_delay.sv
module spi_first_word_delay #(
   parameter int SEL_W      = 3,
   parameter int MIN_LOG    = 2,
   parameter int MAX_LOG    = 5,
   parameter bit SHIFT_IMPL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             tx_write,
   input  logic             master_mode,
   input  logic             single_mode,
   input  logic [SEL_W-1:0] dly_sel,
   input  logic             sclk_tick,
   output logic             start_req
);
   localparam int TGT_W = MAX_LOG + 1;

   logic [TGT_W-1:0] tgt;
   logic             done, clear, load, count_en;

   fwd_decode #(
      .SEL_W(SEL_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG),
      .TGT_W(TGT_W), .SHIFT_IMPL(SHIFT_IMPL)
   ) i_decode (
      .sel(dly_sel), .master_mode(master_mode), .single_mode(single_mode), .tgt(tgt)
   );

   fwd_counter #(.TGT_W(TGT_W)) i_counter (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .load_tgt(tgt),
      .count_en(count_en), .tick(sclk_tick), .done(done)
   );

   fwd_fsm #(.TGT_W(TGT_W)) i_fsm (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tx_write(tx_write),
      .tgt(tgt), .done(done), .clear(clear), .load(load),
      .count_en(count_en), .start_req(start_req)
   );

   // R1: the request is low right after reset release
   assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !start_req);

endmodule

// File: tb/test_spi_first_word_delay.sv
module test_spi_first_word_delay;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_en = 1'b0, tx_write = 1'b0, master_mode = 1'b0, single_mode = 1'b0;
   logic [2:0] dly_sel = 3'd0;
   logic       sclk_tick = 1'b0;
   logic       start_req;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_first_word_delay i_spi_first_word_delay (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tx_write(tx_write),
      .master_mode(master_mode), .single_mode(single_mode), .dly_sel(dly_sel),
      .sclk_tick(sclk_tick), .start_req(start_req)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_len(input int code, input bit m, input bit s);
      if (!(m && s)) return 0;
      if (code >= 1 && code <= 4) return 1 << (code + 1);
      return 0;
   endfunction

   // Enable, write once, then tick every 'gap' cycles; return ticks until start_req.
   task automatic first_word(input int code, input bit m, input bit s, input int gap,
                             input bit chg, output int ticks);
      bit seen;
      chan_en = 1'b1; master_mode = m; single_mode = s; dly_sel = 3'(code);
      @(negedge clk);
      check(start_req == 1'b0, "R2 no write yet", start_req, 0);
      tx_write = 1'b1; sclk_tick = 1'b1;
      @(negedge clk);
      tx_write = 1'b0; sclk_tick = 1'b0;
      if (chg) begin dly_sel = 3'(code ^ 3); master_mode = ~m; end
      ticks = 0;
      seen = start_req;
      while (!seen && ticks < 40) begin
         for (int g = 1; g < gap; g++) begin
            @(negedge clk);
            if (start_req) seen = 1'b1;
         end
         if (!seen) begin
            sclk_tick = 1'b1;
            @(negedge clk);
            sclk_tick = 1'b0;
            ticks++;
            seen = start_req;
         end
      end
   endtask

   task automatic disable_chan;
      chan_en = 1'b0; tx_write = 1'b0; sclk_tick = 1'b0;
      @(negedge clk);
      check(start_req == 1'b0, "R8 disable clears", start_req, 0);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check(start_req == 1'b0, "R1 in reset", start_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(start_req == 1'b0, "R1 after reset", start_req, 0);

      // R3 R4 R5 R6: full sweep over codes, modes and tick spacings
      for (int gap = 1; gap <= 3; gap += 2) begin
         for (int md = 0; md < 4; md++) begin
            for (int code = 0; code < 8; code++) begin
               first_word(code, md[1], md[0], gap, 1'b0, n);
               check(n == exp_len(code, md[1], md[0]), "R3/R4/R5/R6 hold-off length",
                     n, exp_len(code, md[1], md[0]));
               // R7: later writes and ticks keep the request high
               for (int w = 0; w < 3; w++) begin
                  tx_write = 1'b1; sclk_tick = 1'b1;
                  @(negedge clk);
                  tx_write = 1'b0; sclk_tick = 1'b0;
                  @(negedge clk);
                  check(start_req == 1'b1, "R7 stays high", start_req, 1);
               end
               disable_chan();
            end
         end
      end

      // R8: cancel part-way through a hold-off, then re-arm in full
      first_word(2, 1'b1, 1'b1, 1, 1'b0, n);
      check(n == 8, "R8 baseline", n, 8);
      disable_chan();
      chan_en = 1'b1; dly_sel = 3'd2;
      tx_write = 1'b1;
      @(negedge clk);
      tx_write = 1'b0;
      for (int t = 0; t < 5; t++) begin
         sclk_tick = 1'b1; @(negedge clk); sclk_tick = 1'b0;
      end
      check(start_req == 1'b0, "R8 still waiting", start_req, 0);
      disable_chan();
      first_word(2, 1'b1, 1'b1, 1, 1'b0, n);
      check(n == 8, "R8 re-armed length", n, 8);
      disable_chan();

      // R2: a write while disabled is ignored
      chan_en = 1'b0; master_mode = 1'b0; single_mode = 1'b0; dly_sel = 3'd0;
      tx_write = 1'b1;
      @(negedge clk);
      tx_write = 1'b0;
      chan_en = 1'b1;
      for (int t = 0; t < 4; t++) begin
         sclk_tick = 1'b1; @(negedge clk); sclk_tick = 0;
         check(start_req == 1'b0, "R2 disabled write ignored", start_req, 0);
      end
      disable_chan();

      // R9: changing select and mode during the hold-off has no effect
      for (int code = 1; code <= 4; code++) begin
         first_word(code, 1'b1, 1'b1, 2, 1'b1, n);
         check(n == exp_len(code, 1, 1), "R9 captured at write", n, exp_len(code, 1, 1));
         disable_chan();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule